// File: doc/BRIEF.md
# Serial Command Frame Interface

This block is a chip-select-framed serial slave that lets a host program a bank of 4-bit internal registers over a few wires. While the active-low select is asserted, the host clocks in 8-bit frames. Each frame holds a 4-bit register address and a 4-bit data nibble, both sent least-significant bit first. For every completed frame the block raises a one-cycle write strobe in the system clock domain, with the address and the nibble alongside it. Several frames may share one select window.

One particular frame requests a readback. After that frame the block shifts out a 16-bit holding value, most-significant bit first. The holding value is loaded in parallel from the system side. A static mode input picks where the readback goes. In 4-wire mode it goes out on a dedicated output pin. In 3-wire mode the shared serial data pin is turned around, and the block drives it until the 16 bits are done or the select is released.

All serial pins are oversampled by the system clock, so the serial clock must be several times slower than the system clock (at least eight system cycles per serial half-period).

Top module: `serial_cmd_if`

## Requirements
- R1: A frame is 8 serial-clock rising edges while `cs_n` is low. The bits arrive in this order: `wr_addr[0..3]`, then `wr_data[0..3]`. A completed frame gives `wr_stb` high for exactly one system cycle. `wr_addr` and `wr_data` change only with the strobe.
- R2: Frames sent back to back inside one select window are each decoded and strobed on their own, in order.
- R3: Raising `cs_n` before the 8th bit drops the partial frame without any strobe. The next frame after select is asserted again is decoded from its bit 0.
- R4: The frame with address 9 and data 1 (wire order 1,0,0,1,1,0,0,0) is strobed like any other frame. It also starts a readback of the holding value captured at that frame's last bit, bit 15 first.
- R5: Readback bits change only after serial-clock falling edges. The first bit is valid after the falling edge that ends the read frame. The host samples each bit on the following rising edge.
- R6: With `wire3_mode` = 0, readback data appears on `do_o` and `di_oe` stays 0.
- R7: With `wire3_mode` = 1, readback data appears on `di_o` with `di_oe` = 1, and `do_o` stays 0.
- R8: The shared-pin driver is released at the falling edge after the 16th bit, or when `cs_n` goes high in the middle of a readback.
- R9: Serial clock edges during a readback are not framed, whatever `di_i` carries. Framing resumes after the 16th bit.
- R10: After reset, `wr_stb`, `do_o` and `di_oe` are 0.
- R11: Serial clock edges while `cs_n` is high produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wire3_mode | input | 1 | 1 = readback on the shared data pin, 0 = on `do_o` |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data pin, input side |
| di_o | output | 1 | Serial data pin, output value in 3-wire mode |
| di_oe | output | 1 | Serial data pin output enable |
| do_o | output | 1 | Dedicated readback output (4-wire mode) |
| hold_load | input | 1 | Loads `hold_data` into the holding register |
| hold_data | input | 16 | Parallel holding value |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_addr | output | 4 | Register address of the completed frame |
| wr_data | output | 4 | Data nibble of the completed frame |

## Verification
A bit counter that slipped, or that was not cleared on select release, would show up at the next strobe as a wrong address or nibble. It would also show as a missing or extra strobe. The reference queue catches either within one frame. A readback shifter that started at the wrong bit or held data too long shows on the first sampled bit. A driver that stayed enabled shows on `di_oe` half a serial period after the 16th bit, or a few system cycles after select release.

// File: rtl/scif_pkg.sv
package scif_pkg;

    localparam int NIB_W   = 4;
    localparam int FRAME_W = 2 * NIB_W;
    localparam int HOLD_W  = 16;

    // addr occupies the low nibble because it is shifted in first, LSB first
    typedef struct packed {
        logic [NIB_W-1:0] data;
        logic [NIB_W-1:0] addr;
    } frame_t;

    localparam frame_t READ_CMD = '{data: 4'h1, addr: 4'h9};

    function automatic logic is_read(frame_t f);
        return f == READ_CMD;
    endfunction

endpackage

// File: rtl/scif_sync.sv
module scif_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scif_rx.sv
module scif_rx
    import scif_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   abort,
    input  logic   rise,
    input  logic   hold_off,
    input  logic   bit_in,
    output logic   stb,
    output frame_t frame,
    output logic   rd_req
);
    localparam int CNT_W = $clog2(FRAME_W);

    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] sh;
    logic [FRAME_W-1:0] nxt;

    assign nxt = {bit_in, sh[FRAME_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            sh     <= '0;
            stb    <= 1'b0;
            rd_req <= 1'b0;
            frame  <= '0;
        end else if (abort) begin
            cnt    <= '0;
            stb    <= 1'b0;
            rd_req <= 1'b0;
        end else begin
            stb    <= 1'b0;
            rd_req <= 1'b0;
            if (rise && !hold_off) begin
                sh  <= nxt;
                cnt <= cnt + 1'b1;
                if (cnt == CNT_W'(FRAME_W - 1)) begin
                    stb    <= 1'b1;
                    frame  <= frame_t'(nxt);
                    rd_req <= is_read(frame_t'(nxt));
                end
            end
        end
    end
endmodule

// File: rtl/scif_tx.sv
module scif_tx
    import scif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              abort,
    input  logic              fall,
    input  logic              start,
    input  logic [HOLD_W-1:0] hold,
    output logic              busy,
    output logic              bit_out,
    output logic              drive
);
    localparam int CNT_W = $clog2(HOLD_W + 1);

    logic [CNT_W-1:0]  cnt;
    logic [HOLD_W-1:0] shreg;

    always_ff @(posedge clk) begin
        if (rst || abort) begin
            busy    <= 1'b0;
            drive   <= 1'b0;
            bit_out <= 1'b0;
            cnt     <= '0;
            shreg   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            shreg <= hold;
            cnt   <= '0;
        end else if (busy && fall) begin
            if (cnt == CNT_W'(HOLD_W)) begin
                busy    <= 1'b0;
                drive   <= 1'b0;
                bit_out <= 1'b0;
            end else begin
                bit_out <= shreg[HOLD_W-1];
                shreg   <= {shreg[HOLD_W-2:0], 1'b0};
                drive   <= 1'b1;
                cnt     <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_cmd_if.sv
module serial_cmd_if
    import scif_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wire3_mode,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              di_i,
    output logic              di_o,
    output logic              di_oe,
    output logic              do_o,
    input  logic              hold_load,
    input  logic [HOLD_W-1:0] hold_data,
    output logic              wr_stb,
    output logic [NIB_W-1:0]  wr_addr,
    output logic [NIB_W-1:0]  wr_data
);
    logic [2:0]        pins_s;
    logic              cs_s, sclk_s, di_s, sclk_d;
    logic              rise, fall;
    logic [HOLD_W-1:0] hold_q;
    frame_t            frame;
    logic              rd_req, busy, bit_out, drive;

    scif_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d({cs_n, sclk, di_i}), .q(pins_s)
    );
    assign {cs_s, sclk_s, di_s} = pins_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
            hold_q <= '0;
        end else begin
            sclk_d <= sclk_s;
            if (hold_load) hold_q <= hold_data;
        end
    end

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    scif_rx u_rx (
        .clk(clk), .rst(rst), .abort(cs_s), .rise(rise), .hold_off(busy),
        .bit_in(di_s), .stb(wr_stb), .frame(frame), .rd_req(rd_req)
    );

    scif_tx u_tx (
        .clk(clk), .rst(rst), .abort(cs_s), .fall(fall), .start(rd_req),
        .hold(hold_q), .busy(busy), .bit_out(bit_out), .drive(drive)
    );

    assign wr_addr = frame.addr;
    assign wr_data = frame.data;
    assign do_o    = ~wire3_mode & bit_out;
    assign di_o    = bit_out;
    assign di_oe   = wire3_mode & drive;
endmodule

// File: rtl/scif_checker.sv
module scif_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       sclk,
    input logic       di_o,
    input logic       di_oe,
    input logic       do_o,
    input logic       wr_stb,
    input logic [3:0] wr_addr,
    input logic [3:0] wr_data
);
    p_stb_single_r1: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    p_fields_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !wr_stb |-> $stable({wr_addr, wr_data}));

    p_no_stb_idle_r11: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !wr_stb);

    p_release_cs_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !di_oe);

    p_out_steady_r5: assert property (@(posedge clk) disable iff (rst)
        ($past(sclk, 2) && $past(sclk, 3) && $past(sclk, 4) &&
         !$past(cs_n, 2) && !$past(cs_n, 3) && !$past(cs_n, 4))
        |-> ($stable(di_o) && $stable(do_o)));
endmodule

bind serial_cmd_if scif_checker u_chk (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .di_o(di_o),
    .di_oe(di_oe), .do_o(do_o), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data)
);

// File: tb/serial_cmd_if_tb.sv
module serial_cmd_if_tb;
    localparam int CLK_NS = 20;
    localparam int HALF   = 8 * CLK_NS;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wire3_mode = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        di_i = 1'b0;
    logic        hold_load = 1'b0;
    logic [15:0] hold_data = '0;
    logic        di_o, di_oe, do_o, wr_stb;
    logic [3:0]  wr_addr, wr_data;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_q [$];

    always #(CLK_NS/2) clk = ~clk;

    serial_cmd_if u_dut (
        .clk(clk), .rst(rst), .wire3_mode(wire3_mode), .cs_n(cs_n),
        .sclk(sclk), .di_i(di_i), .di_o(di_o), .di_oe(di_oe), .do_o(do_o),
        .hold_load(hold_load), .hold_data(hold_data), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock strobe comparison against the expected frame queue (R1 R2 R3 R9 R11)
    always @(negedge clk) begin
        if (!rst && wr_stb) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected strobe", {wr_data, wr_addr}, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check({wr_data, wr_addr} == e, "R1 strobe fields", {wr_data, wr_addr}, e);
            end
        end
    end

    task automatic clk_bit(input logic b);
        di_i = b;
        #HALF sclk = 1'b1;
        #HALF sclk = 1'b0;
    endtask

    task automatic send_frame(input logic [3:0] a, input logic [3:0] d);
        exp_q.push_back({d, a});
        for (int i = 0; i < 4; i++) clk_bit(a[i]);
        for (int i = 0; i < 4; i++) clk_bit(d[i]);
    endtask

    task automatic load_hold(input logic [15:0] v);
        @(negedge clk);
        hold_data = v; hold_load = 1'b1;
        @(negedge clk);
        hold_load = 1'b0;
    endtask

    // called right after the read frame's final falling edge
    task automatic readback(input logic [15:0] v, input logic three);
        for (int i = 0; i < 16; i++) begin
            #HALF;
            if (three) begin
                check(di_o == v[15-i], "R7 shared pin bit", di_o, v[15-i]);
                check(di_oe == 1'b1, "R7 driver on", di_oe, 1);
                check(do_o == 1'b0, "R7 dedicated pin quiet", do_o, 0);
            end else begin
                check(do_o == v[15-i], "R6 dedicated pin bit", do_o, v[15-i]);
                check(di_oe == 1'b0, "R6 shared pin undriven", di_oe, 0);
            end
            di_i = ~di_i;  // junk during readback, must not be framed (R9)
            sclk = 1'b1;
            #(HALF/2);
            check((three ? di_o : do_o) == v[15-i], "R5 bit held across rising edge",
                  three ? di_o : do_o, v[15-i]);
            #(HALF/2) sclk = 1'b0;
        end
        #HALF;
        check(di_oe == 1'b0, "R8 released after bit 16", di_oe, 0);
    endtask

    initial begin
        #(200000 * CLK_NS);
        check(1'b0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(wr_stb == 1'b0, "R10 reset strobe", wr_stb, 0);
        check(do_o == 1'b0, "R10 reset do_o", do_o, 0);
        check(di_oe == 1'b0, "R10 reset di_oe", di_oe, 0);

        // R1 R2: two frames in one window
        cs_n = 1'b0; #HALF;
        send_frame(4'h3, 4'hA);
        send_frame(4'hC, 4'h5);
        #HALF cs_n = 1'b1;
        #(4 * HALF);
        check(exp_q.size() == 0, "R2 back-to-back frames", exp_q.size(), 0);

        // R11: clocking with select high
        for (int i = 0; i < 10; i++) clk_bit(1'b1);
        #HALF;

        // R3: partial frame aborted, then a clean frame
        cs_n = 1'b0; #HALF;
        for (int i = 0; i < 5; i++) clk_bit(1'b1);
        cs_n = 1'b1; #(2 * HALF);
        cs_n = 1'b0; #HALF;
        send_frame(4'h6, 4'hE);
        #HALF cs_n = 1'b1;
        #(4 * HALF);
        check(exp_q.size() == 0, "R3 frame after abort", exp_q.size(), 0);

        // R4 R6 R9: 4-wire readback, then a frame in the same window
        load_hold(16'hA5C3);
        wire3_mode = 1'b0;
        cs_n = 1'b0; #HALF;
        send_frame(4'h9, 4'h1);
        readback(16'hA5C3, 1'b0);
        send_frame(4'h2, 4'h7);
        #HALF cs_n = 1'b1;
        #(4 * HALF);
        check(exp_q.size() == 0, "R9 framing resumes after readback", exp_q.size(), 0);

        // R4 R7 R8: 3-wire readback
        load_hold(16'h3C96);
        wire3_mode = 1'b1;
        cs_n = 1'b0; #HALF;
        send_frame(4'h9, 4'h1);
        readback(16'h3C96, 1'b1);
        cs_n = 1'b1;
        #(4 * HALF);

        // R8: select released mid-readback
        load_hold(16'hFFFF);
        cs_n = 1'b0; #HALF;
        send_frame(4'h9, 4'h1);
        for (int i = 0; i < 5; i++) begin
            #HALF sclk = 1'b1;
            #HALF sclk = 1'b0;
        end
        #(HALF/2);
        check(di_oe == 1'b1, "R8 driving before release", di_oe, 1);
        cs_n = 1'b1;
        repeat (6) @(negedge clk);
        check(di_oe == 1'b0, "R8 released on select high", di_oe, 0);
        #(4 * HALF);
        check(exp_q.size() == 0, "R4 read frames strobed", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule